// File: doc/BRIEF.md
# Double-Buffered 16-bit PWM Timer

This block produces a pulse-width-modulated output from a 16-bit up-counter. The counter is compared against a duty buffer and a period buffer, not against the software-visible duty and period registers. A period match wraps the counter to zero, raises the PWM flag, and copies both registers into their buffers in the same step. As a result, a new duty or period value written mid-cycle only takes effect at a cycle boundary. While the timer is stopped, writes go straight through to the buffers.

Software reaches the block through a byte-wide write port. The port writes the low and high halves of the counter, the duty value and the period value, plus one control byte. The PWM clock is not a real clock. It is a one-system-cycle enable strobe, chosen from four prescaler taps, and each strobe stands for one active (falling) edge of the PWM clock. All state runs on the single system clock.

Besides the polarity-adjusted output, the block reports:
- a running status bit,
- the raw PWM flag,
- the current count,
- a one-cycle interrupt pulse, placed either at the duty match or at the period match.

Top module: `pwm16_timer`

## Requirements
- R1: After reset the count is 0000h, the flag is 1 (so the output is 1 with polarity bit 0), running status is 0, the interrupt is 0, and all registers and buffers are zero.
- R2: When the run bit (control bit 4) is 1 and running status is 0, the next selected strobe sets running status to 1 and leaves the count unchanged.
- R3: While running, a selected strobe with the count unequal to the period buffer increments the count by one.
- R4: While running, a strobe that finds the count equal to the duty buffer (and unequal to the period buffer) clears the flag; the flag stays 1 up to and including the strobe that reaches the duty value.
- R5: While running, a strobe that finds the count equal to the period buffer sets the count to 0000h and the flag to 1, and loads the duty and period buffers from their registers.
- R6: When the run bit is cleared while running, the next selected strobe still advances the count once and drops running status; later strobes leave the count unchanged.
- R7: Setting the run bit again resumes counting from the held count: the first strobe only restores running status and the second increments.
- R8: A write to address 0 (count low byte) or 1 (count high byte) sets the count to 0000h and the flag to 1, whatever the data.
- R9: Writes to duty (address 2 low, 3 high) and period (address 4 low, 5 high) load the buffer byte at once while running status is 0; while it is 1 they only change the register and reach the buffer at the next period match.
- R10: With duty D below period P, the flag is 1 for D+1 strobes and the output repeats every P+1 strobes.
- R11: Control bits 1:0 select which of the four tap strobes advances the timer; strobes on other taps have no effect.
- R12: The interrupt is a one-system-cycle pulse in the cycle after the strobe that finds a duty match (control bit 2 = 0) or a period match (control bit 2 = 1).
- R13: The output equals the flag XOR control bit 3 (polarity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0..6) |
| wr_data | input | 8 | Write data byte |
| tap_stb | input | 4 | Prescaler tap strobes, one cycle each per PWM-clock edge |
| count_o | output | 16 | Current counter value |
| running_o | output | 1 | Running status |
| flag_o | output | 1 | PWM flag before polarity |
| pwm_o | output | 1 | Polarity-adjusted PWM output |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that each tap strobe is sampled on the system clock edge, and that a counter write in the same cycle as a strobe overrides the strobe's count step. The counter properties are therefore guarded against writes. The stimulus keeps the duty value below the period value, so duty and period matches never coincide. It drives every strobe and register write as a single-cycle pulse set up at the falling clock edge. Held-count and unselected-tap cases are observed through the count and running outputs between strobes.

// File: rtl/pwm16_pkg.sv
package pwm16_pkg;

   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_CNT_LO  = 3'd0,
      A_CNT_HI  = 3'd1,
      A_DUTY_LO = 3'd2,
      A_DUTY_HI = 3'd3,
      A_PER_LO  = 3'd4,
      A_PER_HI  = 3'd5,
      A_CTRL    = 3'd6
   } reg_addr_e;

   localparam int CTRL_W = 5;

   typedef struct packed {
      logic       run;
      logic       invert;
      logic       irq_at_period;
      logic [1:0] tap_sel;
   } ctrl_t;

endpackage

// File: rtl/pwm16_tick_sel.sv
module pwm16_tick_sel #(
   parameter int N_TAPS = 4
) (
   input  logic [N_TAPS-1:0] taps_i,
   input  logic [1:0]        sel_i,
   output logic              tick_o
);
   localparam int SLOTS = 4;

   logic [SLOTS-1:0] slot;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (i < N_TAPS) begin : g_tap
         assign slot[i] = taps_i[i];
      end else begin : g_absent
         assign slot[i] = 1'b0;
      end
   end

   assign tick_o = slot[sel_i];
endmodule

// File: rtl/pwm16_regs.sv
module pwm16_regs
   import pwm16_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [2*BYTE_W-1:0] duty_reg,
   output logic [2*BYTE_W-1:0] per_reg,
   output ctrl_t               ctrl,
   output logic                cnt_wr,
   output logic [1:0]          duty_we,
   output logic [1:0]          per_we
);
   localparam int CW = 2 * BYTE_W;

   assign cnt_wr = wr_en && (wr_addr == A_CNT_LO || wr_addr == A_CNT_HI);

   for (genvar h = 0; h < 2; h++) begin : g_lane
      assign duty_we[h] = wr_en && (wr_addr == ADDR_W'(A_DUTY_LO + h));
      assign per_we[h]  = wr_en && (wr_addr == ADDR_W'(A_PER_LO + h));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            duty_reg[h*BYTE_W +: BYTE_W] <= '0;
            per_reg[h*BYTE_W +: BYTE_W]  <= '0;
         end else begin
            if (duty_we[h]) duty_reg[h*BYTE_W +: BYTE_W] <= wr_data;
            if (per_we[h])  per_reg[h*BYTE_W +: BYTE_W]  <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_en && wr_addr == A_CTRL) begin
         ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   logic unused_hi;
   assign unused_hi = ^{wr_data, CW[0]};
endmodule

// File: rtl/pwm16_core.sv
module pwm16_core #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                run,
   input  logic                irq_at_period,
   input  logic                cnt_wr,
   input  logic [1:0]          duty_we,
   input  logic [1:0]          per_we,
   input  logic [BYTE_W-1:0]   wdata,
   input  logic [2*BYTE_W-1:0] duty_reg,
   input  logic [2*BYTE_W-1:0] per_reg,
   output logic [2*BYTE_W-1:0] cnt,
   output logic                run_stat,
   output logic                flag,
   output logic                irq
);
   localparam int CW = 2 * BYTE_W;
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] duty_buf, per_buf;
   logic          per_hit, duty_hit, step;

   assign per_hit  = (cnt == per_buf);
   assign duty_hit = (cnt == duty_buf);
   assign step     = tick && run_stat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         run_stat <= 1'b0;
         flag     <= 1'b1;
         irq      <= 1'b0;
         duty_buf <= '0;
         per_buf  <= '0;
      end else begin
         irq <= 1'b0;
         if (step) begin
            if (per_hit) begin
               cnt      <= '0;
               flag     <= 1'b1;
               duty_buf <= duty_reg;
               per_buf  <= per_reg;
               irq      <= irq_at_period;
            end else begin
               cnt <= cnt + ONE;
               if (duty_hit) flag <= 1'b0;
               irq <= !irq_at_period && duty_hit;
            end
            run_stat <= run;
         end else if (tick && run) begin
            run_stat <= 1'b1;
         end
         if (!run_stat) begin
            for (int h = 0; h < 2; h++) begin
               if (duty_we[h]) duty_buf[h*BYTE_W +: BYTE_W] <= wdata;
               if (per_we[h])  per_buf[h*BYTE_W +: BYTE_W]  <= wdata;
            end
         end
         if (cnt_wr) begin
            cnt  <= '0;
            flag <= 1'b1;
         end
      end
   end

   p_start_no_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !run_stat && !cnt_wr) |=> (run_stat && $stable(cnt)));

   p_increment_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !per_hit && !cnt_wr) |=> (cnt == $past(cnt) + ONE));

   p_duty_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && duty_hit && !per_hit && !cnt_wr) |=> !flag);

   p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && per_hit && !cnt_wr) |=> (cnt == '0 && flag));

   p_hold_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_stat && !cnt_wr) |=> $stable(cnt));

   p_stop_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_stat) |-> $past(tick));

   p_cnt_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt == '0 && flag));

   p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(step));
endmodule

// File: rtl/pwm16_timer.sv
module pwm16_timer
   import pwm16_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int N_TAPS = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [BYTE_W-1:0]   wr_data,
   input  logic [N_TAPS-1:0]   tap_stb,
   output logic [2*BYTE_W-1:0] count_o,
   output logic                running_o,
   output logic                flag_o,
   output logic                pwm_o,
   output logic                irq_o
);
   localparam int CW = 2 * BYTE_W;

   if (BYTE_W < CTRL_W) begin : g_bad_byte
      $error("BYTE_W must hold the control fields");
   end
   if (N_TAPS < 1 || N_TAPS > 4) begin : g_bad_taps
      $error("N_TAPS must be 1 to 4");
   end

   logic [CW-1:0] duty_reg, per_reg;
   ctrl_t         ctrl;
   logic          cnt_wr, tick;
   logic [1:0]    duty_we, per_we;

   pwm16_regs #(.BYTE_W(BYTE_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .duty_reg (duty_reg),
      .per_reg  (per_reg),
      .ctrl     (ctrl),
      .cnt_wr   (cnt_wr),
      .duty_we  (duty_we),
      .per_we   (per_we)
   );

   pwm16_tick_sel #(.N_TAPS(N_TAPS)) i_tick (
      .taps_i (tap_stb),
      .sel_i  (ctrl.tap_sel),
      .tick_o (tick)
   );

   pwm16_core #(.BYTE_W(BYTE_W)) i_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .run           (ctrl.run),
      .irq_at_period (ctrl.irq_at_period),
      .cnt_wr        (cnt_wr),
      .duty_we       (duty_we),
      .per_we        (per_we),
      .wdata         (wr_data),
      .duty_reg      (duty_reg),
      .per_reg       (per_reg),
      .cnt           (count_o),
      .run_stat      (running_o),
      .flag          (flag_o),
      .irq           (irq_o)
   );

   assign pwm_o = flag_o ^ ctrl.invert;

   p_polarity_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.invert && $stable(ctrl)) |-> (pwm_o != flag_o));
endmodule

// File: tb/test_pwm16_timer.sv
`timescale 1ns/1ps
module test_pwm16_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  tap_stb = '0;
   logic [15:0] count_o;
   logic        running_o, flag_o, pwm_o, irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pwm16_timer i_pwm16_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .tap_stb(tap_stb), .count_o(count_o),
      .running_o(running_o), .flag_o(flag_o), .pwm_o(pwm_o), .irq_o(irq_o)
   );

   localparam int NV = 6;
   localparam logic [15:0] VEC_D [NV] = '{16'd0, 16'd1, 16'd2, 16'd4, 16'd0, 16'h0100};
   localparam logic [15:0] VEC_P [NV] = '{16'd1, 16'd3, 16'd5, 16'd5, 16'd4, 16'h0102};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int t);
      @(negedge clk);
      tap_stb[t] = 1'b1;
      @(negedge clk);
      tap_stb = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(count_o == 0, "R1 count", count_o, 0);
      chk(pwm_o == 1 && flag_o == 1, "R1 flag", flag_o, 1);
      chk(running_o == 0, "R1 running", running_o, 0);
      chk(irq_o == 0, "R1 irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // stopped: direct buffer loads, duty 3 period 10 (R9)
      wr(3'd2, 8'd3);
      wr(3'd4, 8'd10);
      wr(3'd6, 8'h10);
      chk(running_o == 0, "R2 no strobe yet", running_o, 0);
      tick(1);
      chk(running_o == 0, "R11 other tap ignored while starting", running_o, 0);
      tick(0);
      chk(running_o == 1, "R2 running after first strobe", running_o, 1);
      chk(count_o == 0, "R2 count unchanged", count_o, 0);
      tick(1);
      chk(count_o == 0, "R11 unselected tap", count_o, 0);
      tick(0);
      chk(count_o == 1, "R3 increment", count_o, 1);
      tick(0); tick(0);
      chk(count_o == 3 && pwm_o == 1, "R4 high at duty value", pwm_o, 1);
      tick(0);
      chk(count_o == 4 && pwm_o == 0, "R4 cleared after duty match", pwm_o, 0);
      chk(irq_o == 1, "R12 duty irq", irq_o, 1);
      @(negedge clk);
      chk(irq_o == 0, "R12 single cycle", irq_o, 0);

      // running write of period 6 must wait for the wrap (R9)
      wr(3'd4, 8'd6);
      wr(3'd6, 8'h14);
      repeat (6) tick(0);
      chk(count_o == 10, "R9 old period still used", count_o, 10);
      chk(irq_o == 0, "R12 no irq at duty when period selected", irq_o, 0);
      tick(0);
      chk(count_o == 0 && pwm_o == 1, "R5 wrap", count_o, 0);
      chk(irq_o == 1, "R12 period irq", irq_o, 1);
      repeat (6) tick(0);
      chk(count_o == 6, "R9 reached new period", count_o, 6);
      tick(0);
      chk(count_o == 0, "R9 new period loaded at wrap", count_o, 0);

      // stop and resume (R6, R7)
      tick(0); tick(0);
      wr(3'd6, 8'h04);
      chk(running_o == 1, "R6 still running before strobe", running_o, 1);
      tick(0);
      chk(count_o == 3 && running_o == 0, "R6 one more advance", count_o, 3);
      tick(0);
      chk(count_o == 3, "R6 held", count_o, 3);
      wr(3'd6, 8'h14);
      tick(0);
      chk(running_o == 1 && count_o == 3, "R7 restart edge", count_o, 3);
      tick(0);
      chk(count_o == 4 && pwm_o == 0, "R7 resumed from held value", count_o, 4);

      // counter write (R8)
      wr(3'd1, 8'h55);
      chk(count_o == 0 && pwm_o == 1, "R8 count write clears", count_o, 0);

      // polarity (R13)
      wr(3'd6, 8'h1C);
      chk(pwm_o == 0 && flag_o == 1, "R13 inverted high", pwm_o, 0);
      repeat (4) tick(0);
      chk(pwm_o == 1 && flag_o == 0, "R13 inverted low", pwm_o, 1);

      // vector table: duty/period waveform (R10)
      for (int v = 0; v < NV; v++) begin
         int high;
         wr(3'd6, 8'h00);
         tick(0);
         wr(3'd2, VEC_D[v][7:0]);
         wr(3'd3, VEC_D[v][15:8]);
         wr(3'd4, VEC_P[v][7:0]);
         wr(3'd5, VEC_P[v][15:8]);
         wr(3'd0, 8'h00);
         wr(3'd6, 8'h10);
         tick(0);
         high = 0;
         for (int i = 0; i <= int'(VEC_P[v]); i++) begin
            if (pwm_o) high++;
            tick(0);
         end
         chk(high == int'(VEC_D[v]) + 1, "R10 high time", high, int'(VEC_D[v]) + 1);
         chk(count_o == 0 && pwm_o == 1, "R10 period length", count_o, 0);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule